// File: doc/BRIEF.md
# Synchronous Dual-Bus Static RAM with Port-to-Port Streaming

This block models a synchronous static RAM with two separate data buses: a processor port and a system port. Each stored word has nine bits, eight data bits and one parity bit. The parity bit is stored and returned like any other bit, and the block does not check or generate it. Both ports share one address bus, one write enable and one input enable per port. The address is captured on the falling clock edge. The enables and the port data are captured on the rising edge. Each port's output passes through a latch that follows its input while the clock is high and holds while the clock is low. Each port has an output enable that gates its output at once, with no clock involved.

Either port can write the array, and the array can be read out on either port. A word captured on one port can also be shown on the other port's output without passing through the array. This streaming works in either direction and may take place in the same cycle as a write. A build-time parameter selects separate-I/O use. In that mode the system input enable and the processor output enable are forced inactive, so the processor bus only writes and the system bus only reads.

Top module: `dual_bus_sram`

## Requirements
- R1: A write cycle takes place when write enable is low and the processor input enable is low at a rising edge. It stores the 9-bit processor word at the address captured on the falling edge before. A read cycle has write enable high and both input enables high at a rising edge. After that edge, a read cycle returns the stored word on both ports during the high phase.
- R2: A write cycle with the system input enable low and the processor input enable high stores the 9-bit system word.
- R3: The address is sampled only on the falling clock edge. A change after that edge and before the next rising edge does not alter which word is written.
- R4: Write enable, both input enables and both data buses are sampled only on the rising edge. A write-enable pulse that starts and ends between two rising edges writes nothing.
- R5: Each port output follows its latch input while the clock is high. It holds the value present at the falling edge for the whole low phase, even when the captured address has changed.
- R6: When an output enable is high (inactive), that port's drive flag is 0 and its data output reads 0 at once, with no clock edge needed.
- R7: When the processor input enable is sampled low, the system output shows the captured processor word instead of array data. With write enable high, the array is left unchanged.
- R8: When the system input enable is sampled low, the processor output shows the captured system word instead of array data.
- R9: A cycle with write enable low and the processor input enable low streams the processor word to the system output and also writes it to the array.
- R10: With SEPARATE_IO=1, the processor drive flag stays 0 whatever its output enable is, and a low system input enable is ignored. A write with only the system input enable low therefore stores nothing.
- R11: While reset is asserted and both output enables are high, both drive flags and both data outputs are 0.
- R12: When both input enables are low in a write cycle, the processor word is written. Each port's output shows the other port's captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; address captured on the falling edge, all else on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the capture registers and hold latches |
| addr | input | ADDR_W | Shared word address |
| wr_n | input | 1 | Write enable, active low |
| p_in_en_n | input | 1 | Processor input enable, active low |
| s_in_en_n | input | 1 | System input enable, active low |
| p_out_en_n | input | 1 | Processor output enable, active low, asynchronous |
| s_out_en_n | input | 1 | System output enable, active low, asynchronous |
| p_din | input | DATA_W+1 | Processor data in (parity in the top bit) |
| s_din | input | DATA_W+1 | System data in (parity in the top bit) |
| p_dout | output | DATA_W+1 | Processor data out, 0 when not driven |
| p_doe | output | 1 | Processor drive flag (1 = driving, 0 = high impedance) |
| s_dout | output | DATA_W+1 | System data out, 0 when not driven |
| s_doe | output | 1 | System drive flag (1 = driving, 0 = high impedance) |

## Verification
The bench moves the address between the falling and the rising edge. A design that captured the address on the rising edge would write the wrong word. It also pulses write enable between rising edges, which a level-sensitive write would act on. It reads one word and then presents a new address, and checks the output during the low phase. A latch that is not held would already show the new word there. The streaming checks look at both outputs in the same cycle, and some of them check that the array was not touched. A swapped cross-path or a stray write would show up there. A separate-I/O instance runs on the same stimulus and shows whether the forced tie-offs really block the system input path and the processor drive.

// File: rtl/dual_bus_sram_pkg.sv
`timescale 1ns/1ps
package dual_bus_sram_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PROC = 2'd1,
    SRC_SYS  = 2'd2
  } wsrc_e;

  // Write-data source: processor wins when both inputs are enabled.
  function automatic wsrc_e pick_wsrc(input logic pie_n, input logic sie_n);
    if (!pie_n)      return SRC_PROC;
    else if (!sie_n) return SRC_SYS;
    else             return SRC_NONE;
  endfunction

  // A port shows its peer's captured word when the peer input is enabled.
  function automatic logic show_peer(input logic peer_in_en_n);
    return !peer_in_en_n;
  endfunction

endpackage

// File: rtl/bus_capture.sv
`timescale 1ns/1ps
module bus_capture #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pie_n,
  input  logic              sie_n,
  input  logic [WORD_W-1:0] p_din,
  input  logic [WORD_W-1:0] s_din,
  output logic [ADDR_W-1:0] addr_q,
  output logic              pie_q_n,
  output logic              sie_q_n,
  output logic [WORD_W-1:0] p_reg,
  output logic [WORD_W-1:0] s_reg
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pie_q_n <= 1'b1;
      sie_q_n <= 1'b1;
      p_reg   <= '0;
      s_reg   <= '0;
    end else begin
      pie_q_n <= pie_n;
      sie_q_n <= sie_n;
      p_reg   <= p_din;
      s_reg   <= s_din;
    end
  end

endmodule

// File: rtl/sram_core.sv
`timescale 1ns/1ps
module sram_core #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 9,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/out_latch.sv
`timescale 1ns/1ps
module out_latch #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] held;

  // Value frozen at the falling edge covers the whole low phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= d;
  end

  assign q = clk ? d : held;

endmodule

// File: rtl/dual_bus_sram.sv
`timescale 1ns/1ps
module dual_bus_sram
  import dual_bus_sram_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int DATA_W      = 8,
  parameter bit SEPARATE_IO = 1'b0,
  parameter int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic              p_in_en_n,
  input  logic              s_in_en_n,
  input  logic              p_out_en_n,
  input  logic              s_out_en_n,
  input  logic [DATA_W:0]   p_din,
  input  logic [DATA_W:0]   s_din,
  output logic [DATA_W:0]   p_dout,
  output logic              p_doe,
  output logic [DATA_W:0]   s_dout,
  output logic              s_doe
);

  localparam int WORD_W = DATA_W + 1;

  logic              sie_eff_n;
  logic              p_drive;
  logic [ADDR_W-1:0] addr_q;
  logic              pie_q_n, sie_q_n;
  logic [WORD_W-1:0] p_reg, s_reg;
  logic [WORD_W-1:0] rdata, wdata;
  logic [WORD_W-1:0] p_lat_d, s_lat_d, p_lat, s_lat;
  wsrc_e             wsrc_now;
  logic              wr_fire;

  generate
    if (SEPARATE_IO) begin : g_sep
      assign sie_eff_n = 1'b1;
      assign p_drive   = 1'b0;
    end else begin : g_dual
      assign sie_eff_n = s_in_en_n;
      assign p_drive   = !p_out_en_n;
    end
  endgenerate

  bus_capture #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .pie_n(p_in_en_n), .sie_n(sie_eff_n),
    .p_din(p_din), .s_din(s_din),
    .addr_q(addr_q), .pie_q_n(pie_q_n), .sie_q_n(sie_q_n),
    .p_reg(p_reg), .s_reg(s_reg)
  );

  // Write fires on the rising edge that samples the controls and data.
  assign wsrc_now = pick_wsrc(p_in_en_n, sie_eff_n);
  assign wr_fire  = !wr_n && (wsrc_now != SRC_NONE);
  assign wdata    = (wsrc_now == SRC_PROC) ? p_din : s_din;

  sram_core #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) core_i (
    .clk(clk), .we(wr_fire), .waddr(addr_q), .wdata(wdata),
    .raddr(addr_q), .rdata(rdata)
  );

  assign p_lat_d = show_peer(sie_q_n) ? s_reg : rdata;
  assign s_lat_d = show_peer(pie_q_n) ? p_reg : rdata;

  out_latch #(.WORD_W(WORD_W)) p_lat_i (.clk(clk), .rst_n(rst_n), .d(p_lat_d), .q(p_lat));
  out_latch #(.WORD_W(WORD_W)) s_lat_i (.clk(clk), .rst_n(rst_n), .d(s_lat_d), .q(s_lat));

  assign p_doe  = p_drive;
  assign s_doe  = !s_out_en_n;
  assign p_dout = p_doe ? p_lat : '0;
  assign s_dout = s_doe ? s_lat : '0;

endmodule

// File: rtl/dual_bus_sram_chk.sv
`timescale 1ns/1ps
module dual_bus_sram_chk #(
  parameter int ADDR_W      = 8,
  parameter int WORD_W      = 9,
  parameter bit SEPARATE_IO = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] addr_q,
  input logic              p_in_en_n,
  input logic              s_in_en_n,
  input logic              p_out_en_n,
  input logic              s_out_en_n,
  input logic [WORD_W-1:0] p_din,
  input logic [WORD_W-1:0] s_din,
  input logic [WORD_W-1:0] p_lat,
  input logic [WORD_W-1:0] s_lat,
  input logic              p_doe,
  input logic              s_doe
);

  AST_ADDR_ON_FALL: assert property (@(negedge clk) disable iff (!rst_n)
    ##1 (addr_q == $past(addr))); // R3

  AST_STREAM_P2S: assert property (@(posedge clk) disable iff (!rst_n)
    !p_in_en_n |=> (s_lat == $past(p_din))); // R7

  AST_STREAM_S2P: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_in_en_n && !SEPARATE_IO) |=> (p_lat == $past(s_din))); // R8

  AST_P_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    p_out_en_n |-> !p_doe); // R6

  AST_S_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    s_out_en_n |-> !s_doe); // R6

endmodule

bind dual_bus_sram dual_bus_sram_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SEPARATE_IO(SEPARATE_IO)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .addr_q(addr_q),
  .p_in_en_n(p_in_en_n), .s_in_en_n(s_in_en_n),
  .p_out_en_n(p_out_en_n), .s_out_en_n(s_out_en_n),
  .p_din(p_din), .s_din(s_din), .p_lat(p_lat), .s_lat(s_lat),
  .p_doe(p_doe), .s_doe(s_doe)
);

// File: tb/dual_bus_sram_tb_top.sv
`timescale 1ns/1ps
module dual_bus_sram_tb_top;

  localparam int DEPTH  = 256;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_n = 1'b1, pie_n = 1'b1, sie_n = 1'b1, poe_n = 1'b1, soe_n = 1'b1;
  logic [8:0] p_din = '0, s_din = '0;
  logic [8:0] p_dout, s_dout, sep_p_dout, sep_s_dout;
  logic p_doe, s_doe, sep_p_doe, sep_s_doe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  dual_bus_sram #(.DEPTH(DEPTH), .DATA_W(8), .SEPARATE_IO(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_n(wr_n),
    .p_in_en_n(pie_n), .s_in_en_n(sie_n), .p_out_en_n(poe_n), .s_out_en_n(soe_n),
    .p_din(p_din), .s_din(s_din),
    .p_dout(p_dout), .p_doe(p_doe), .s_dout(s_dout), .s_doe(s_doe)
  );

  dual_bus_sram #(.DEPTH(DEPTH), .DATA_W(8), .SEPARATE_IO(1'b1)) dut_sep (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_n(wr_n),
    .p_in_en_n(pie_n), .s_in_en_n(sie_n), .p_out_en_n(poe_n), .s_out_en_n(soe_n),
    .p_din(p_din), .s_din(s_din),
    .p_dout(sep_p_dout), .p_doe(sep_p_doe), .s_dout(sep_s_dout), .s_doe(sep_s_doe)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Advance to just after the next rising edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_cyc(input logic [7:0] a, input logic w, input logic pe, input logic se,
                         input logic [8:0] pd, input logic [8:0] sd);
    addr = a; wr_n = w; pie_n = pe; sie_n = se; p_din = pd; s_din = sd;
  endtask

  task automatic write_p(input logic [7:0] a, input logic [8:0] d);
    set_cyc(a, 1'b0, 1'b0, 1'b1, d, 9'h000);
    tick();
  endtask

  task automatic read_both(input logic [7:0] a, input logic [8:0] exp, input string req);
    set_cyc(a, 1'b1, 1'b1, 1'b1, 9'h000, 9'h000);
    tick();
    chk(req, p_dout, exp);
    chk(req, s_dout, exp);
  endtask

  task automatic t_reset();
    chk("R11 p_doe", {8'h0, p_doe}, 9'h000);
    chk("R11 s_doe", {8'h0, s_doe}, 9'h000);
    chk("R11 p_dout", p_dout, 9'h000);
    chk("R11 s_dout", s_dout, 9'h000);
  endtask

  task automatic t_write_read();
    write_p(8'd5, 9'h1A5);
    read_both(8'd5, 9'h1A5, "R1 read after processor write");
    write_p(8'd6, 9'h077);
    set_cyc(8'd6, 1'b0, 1'b1, 1'b0, 9'h000, 9'h0C3);
    tick();
    read_both(8'd6, 9'h0C3, "R2 read after system write");
    chk("R10 sep ignores system input", sep_s_dout, 9'h077);
    chk("R10 sep processor never drives", {8'h0, sep_p_doe}, 9'h000);
  endtask

  task automatic t_sample_edges();
    write_p(8'd11, 9'h022);
    write_p(8'd13, 9'h0AB);
    set_cyc(8'd10, 1'b0, 1'b0, 1'b1, 9'h111, 9'h000);
    #2; addr = 8'd11;
    tick();
    read_both(8'd10, 9'h111, "R3 falling-edge address used");
    read_both(8'd11, 9'h022, "R3 late address not written");
    set_cyc(8'd13, 1'b0, 1'b0, 1'b1, 9'h1CD, 9'h000);
    #2; wr_n = 1'b1; pie_n = 1'b1;
    tick();
    read_both(8'd13, 9'h0AB, "R4 pulse between edges ignored");
  endtask

  task automatic t_hold();
    read_both(8'd5, 9'h1A5, "R5 high phase");
    set_cyc(8'd6, 1'b1, 1'b1, 1'b1, 9'h000, 9'h000);
    #2;
    chk("R5 low-phase hold", s_dout, 9'h1A5);
    chk("R5 low-phase hold p", p_dout, 9'h1A5);
    tick();
    chk("R5 next high phase", s_dout, 9'h0C3);
  endtask

  task automatic t_async_oe();
    soe_n = 1'b1;
    #0.2;
    chk("R6 s off data", s_dout, 9'h000);
    chk("R6 s off flag", {8'h0, s_doe}, 9'h000);
    poe_n = 1'b1;
    #0.2;
    chk("R6 p off data", p_dout, 9'h000);
    poe_n = 1'b0; soe_n = 1'b0;
    #0.2;
    chk("R6 s back on", s_dout, 9'h0C3);
    chk("R6 p back on", p_dout, 9'h0C3);
  endtask

  task automatic t_stream();
    write_p(8'd20, 9'h0EE);
    set_cyc(8'd20, 1'b1, 1'b0, 1'b1, 9'h13C, 9'h000);
    tick();
    chk("R7 p->s stream", s_dout, 9'h13C);
    chk("R7 p shows array", p_dout, 9'h0EE);
    set_cyc(8'd20, 1'b1, 1'b1, 1'b0, 9'h000, 9'h0D2);
    tick();
    chk("R8 s->p stream", p_dout, 9'h0D2);
    chk("R8 s shows array", s_dout, 9'h0EE);
    read_both(8'd20, 9'h0EE, "R7 array untouched by stream");
    set_cyc(8'd21, 1'b0, 1'b0, 1'b1, 9'h171, 9'h000);
    tick();
    chk("R9 stream during write", s_dout, 9'h171);
    read_both(8'd21, 9'h171, "R9 streamed word written");
    set_cyc(8'd22, 1'b0, 1'b0, 1'b0, 9'h101, 9'h0FE);
    tick();
    chk("R12 p shows system word", p_dout, 9'h0FE);
    chk("R12 s shows processor word", s_dout, 9'h101);
    chk("R10 sep p stays off", {8'h0, sep_p_doe}, 9'h000);
    read_both(8'd22, 9'h101, "R12 processor wins write");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #7;
    t_reset();
    rst_n = 1'b1;
    poe_n = 1'b0; soe_n = 1'b0;
    tick();
    t_write_read();
    t_sample_edges();
    t_hold();
    t_async_oe();
    t_stream();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule